// File: doc/BRIEF.md
# Six-Tap Subpixel Interpolation Filter

This block produces motion-compensated prediction rows at eighth-pel accuracy. Each job names a fraction index (1 to 7) and a tap count (six or four) for the horizontal and the vertical direction, a row width of 4, 8 or 16 pixels, and a row count. Reference rows are then streamed in, one per handshake. Every row carries two pixels of margin on the left and three on the right. Filtered 8-bit rows leave through a valid/ready output port.

Three modes exist. Horizontal-only filtering turns every input row into one output row. Vertical-only filtering keeps a window of recent rows, and the first output is produced only once the taps above and below are in hand. Two-dimensional filtering filters each incoming row horizontally and rounds it to 8 bits. It then runs the vertical kernel over a window of those intermediate rows. Each produced row slides the window down by one row.

Every tap sum is offset by 64, arithmetically shifted right by 7 and saturated to the 0..255 range.

Top module: `subpel_filter`

## Requirements
- R1: In horizontal mode (cfg_mode=1), output pixel c of a row is clamp((sum over i=0..5 of k[i]*p[c+i] + 64) >> 7). Here p[b] is byte b of in_row (byte b sits at bits 8b+7:8b and holds column b-2). k is the kernel row selected by fraction f: f=1 {0,-6,123,12,-1,0}, f=2 {2,-11,108,36,-8,1}, f=3 {0,-9,93,50,-6,0}, f=4 {3,-16,77,77,-16,3}, f=5 {0,-6,50,93,-9,0}, f=6 {1,-8,36,108,-11,2}, f=7 {0,-1,12,123,-6,0}.
- R2: With the tap-size bit of a direction at 0 (four-tap), the outermost coefficients k[0] and k[5] of that direction are taken as zero, so only offsets -1..+2 contribute.
- R3: Every result is saturated: sums below zero give 0 and sums above 255 give 255.
- R4: In vertical mode (cfg_mode=2), a job consumes rows+5 input rows when the vertical kernel is six-tap and rows+3 otherwise. Output row r is the vertical kernel applied to the centre columns (byte c+2) of input rows r..r+5 (six-tap) or r..r+3 (four-tap).
- R5: In two-dimensional mode (cfg_mode=3), each input row is first filtered horizontally and rounded to 8 bits. If either direction is six-tap, the job consumes rows+5 input rows and the vertical taps at offsets -2..+3 use intermediate rows r..r+5. Otherwise it consumes rows+3 input rows and offsets -1..+2 use intermediate rows r..r+3.
- R6: After priming, every accepted input row yields exactly one output row, and the filter window advances by one row.
- R7: The width code cfg_width selects 4 (0), 8 (1) or 16 (2) valid lanes. Output bytes at and above that width are zero.
- R8: A job emits exactly cfg_rows output rows (cfg_rows at least 1), and busy falls once the last one is taken.
- R9: While out_valid is high and out_ready low, out_row holds its value and in_ready stays low.
- R10: During and right after reset, out_valid, busy and in_ready are low.
- R11: start is taken only while busy is low. Configuration changes and start pulses during a job have no effect on it, and in_ready is low while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches a job with the cfg_* values when idle |
| cfg_mode | input | 2 | 1 horizontal, 2 vertical, 3 two-dimensional |
| cfg_frac_h | input | 3 | Horizontal fraction index 1..7 |
| cfg_frac_v | input | 3 | Vertical fraction index 1..7 |
| cfg_h6 | input | 1 | Horizontal kernel six-tap (1) or four-tap (0) |
| cfg_v6 | input | 1 | Vertical kernel six-tap (1) or four-tap (0) |
| cfg_width | input | 2 | Width code: 0=4, 1=8, 2=16 lanes |
| cfg_rows | input | ROWS_W | Output rows in the job (at least 1) |
| busy | output | 1 | A job or an untaken output row is pending |
| in_valid | input | 1 | in_row holds a reference row |
| in_ready | output | 1 | The block takes in_row on this edge if in_valid |
| in_row | input | (MAX_W+5)*8 | Reference row with margins, byte b = column b-2 |
| out_valid | output | 1 | out_row holds a filtered row |
| out_ready | input | 1 | Consumer takes out_row |
| out_row | output | MAX_W*8 | Filtered row, byte c = column c |

## Verification
Some properties are checked on every cycle: the handshake rules (output held and input stalled under back-pressure, no input taken while idle), the zeroing of lanes beyond the chosen width, the per-job count of emitted rows, and legal fraction indices at launch. The arithmetic can only be shown by the bench's scenarios, in which a behavioural model recomputes every row: the kernel values, the four-tap trimming, saturation, the priming depth for each mix of tap sizes, and the sliding window across many rows.

// File: rtl/subpel_pkg.sv
package subpel_pkg;
  localparam int TAPS   = 6;
  localparam int COEF_W = 8;

  typedef logic signed [COEF_W-1:0] coef_t;
  // index 0 weighs offset -2, index TAPS-1 weighs offset +3
  typedef coef_t [TAPS-1:0] kern_t;

  typedef enum logic [1:0] {
    MD_NONE = 2'd0,
    MD_H    = 2'd1,
    MD_V    = 2'd2,
    MD_HV   = 2'd3
  } mode_e;

  // concatenations list the weights from offset +3 down to offset -2
  function automatic kern_t pick_kernel(input logic [2:0] frac, input logic six);
    kern_t k;
    case (frac)
      3'd1:    k = {8'sd0,  -8'sd1,  8'sd12,  8'sd123, -8'sd6,  8'sd0};
      3'd2:    k = {8'sd1,  -8'sd8,  8'sd36,  8'sd108, -8'sd11, 8'sd2};
      3'd3:    k = {8'sd0,  -8'sd6,  8'sd50,  8'sd93,  -8'sd9,  8'sd0};
      3'd4:    k = {8'sd3,  -8'sd16, 8'sd77,  8'sd77,  -8'sd16, 8'sd3};
      3'd5:    k = {8'sd0,  -8'sd9,  8'sd93,  8'sd50,  -8'sd6,  8'sd0};
      3'd6:    k = {8'sd2,  -8'sd11, 8'sd108, 8'sd36,  -8'sd8,  8'sd1};
      3'd7:    k = {8'sd0,  -8'sd6,  8'sd123, 8'sd12,  -8'sd1,  8'sd0};
      default: k = '0;
    endcase
    if (!six) begin
      k[0]      = '0;
      k[TAPS-1] = '0;
    end
    return k;
  endfunction
endpackage

// File: rtl/subpel_tap_mac.sv
module subpel_tap_mac
  import subpel_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int ACC_W = 18,
  parameter int SHIFT = 7
) (
  input  logic [TAPS-1:0][PIX_W-1:0] smp,
  input  kern_t                      coef,
  output logic [PIX_W-1:0]           pix
);
  localparam int RND  = 1 << (SHIFT - 1);
  localparam int PMAX = (1 << PIX_W) - 1;

  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] scl;

  always_comb begin
    acc = ACC_W'(RND);
    for (int i = 0; i < TAPS; i++) begin
      acc = acc + ACC_W'($signed({1'b0, smp[i]})) * ACC_W'($signed(coef[i]));
    end
    scl = acc >>> SHIFT;
    if (scl < 0)
      pix = '0;
    else if (scl > ACC_W'(PMAX))
      pix = '1;
    else
      pix = scl[PIX_W-1:0];
  end
endmodule

// File: rtl/subpel_row_filter.sv
module subpel_row_filter
  import subpel_pkg::*;
#(
  parameter int LANES = 16,
  parameter int PIX_W = 8,
  parameter int ACC_W = 18,
  parameter int SHIFT = 7
) (
  input  logic [LANES+TAPS-2:0][PIX_W-1:0] row,
  input  kern_t                            coef,
  output logic [LANES-1:0][PIX_W-1:0]      pix
);
  for (genvar c = 0; c < LANES; c++) begin : g_lane
    subpel_tap_mac #(.PIX_W(PIX_W), .ACC_W(ACC_W), .SHIFT(SHIFT)) u_mac (
      .smp  (row[c +: TAPS]),
      .coef (coef),
      .pix  (pix[c])
    );
  end
endmodule

// File: rtl/subpel_filter.sv
module subpel_filter
  import subpel_pkg::*;
#(
  parameter int MAX_W  = 16,
  parameter int PIX_W  = 8,
  parameter int ROWS_W = 5,
  parameter int ACC_W  = 18,
  parameter int SHIFT  = 7
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               start,
  input  logic [1:0]                         cfg_mode,
  input  logic [2:0]                         cfg_frac_h,
  input  logic [2:0]                         cfg_frac_v,
  input  logic                               cfg_h6,
  input  logic                               cfg_v6,
  input  logic [1:0]                         cfg_width,
  input  logic [ROWS_W-1:0]                  cfg_rows,
  output logic                               busy,
  input  logic                               in_valid,
  output logic                               in_ready,
  input  logic [(MAX_W+TAPS-1)*PIX_W-1:0]    in_row,
  output logic                               out_valid,
  input  logic                               out_ready,
  output logic [MAX_W*PIX_W-1:0]             out_row
);
  localparam int IN_W        = MAX_W + TAPS - 1;
  localparam int WIN         = TAPS - 1;
  localparam int LEFT_MARGIN = (TAPS / 2) - 1;
  localparam logic [2:0] PRIME_TALL  = 3'(TAPS - 1);
  localparam logic [2:0] PRIME_SHORT = 3'(TAPS - 3);

  typedef logic [MAX_W-1:0][PIX_W-1:0] lrow_t;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  // control state
  logic              busy_q, busy_n;
  logic              ov_q, ov_n;
  logic [2:0]        prime_q, prime_n;
  logic [ROWS_W-1:0] left_q, left_n;
  // job configuration and datapath state
  mode_e             mode_q;
  kern_t             kh_q, kv_q;
  logic              tall_q;
  logic [1:0]        wcode_q;
  lrow_t [WIN-1:0]   win_q, win_n;
  lrow_t             orow_q;

  logic [IN_W-1:0][PIX_W-1:0]             in_pk;
  lrow_t                                  hrow, vrow, raw, new_ent, res;
  logic [MAX_W-1:0][TAPS-1:0][PIX_W-1:0]  vsmp;
  logic  start_ok, take, cfg_tall;

  assign in_pk    = in_row;
  assign start_ok = start && !busy_q && !ov_q;
  assign in_ready = busy_q && (!ov_q || out_ready);
  assign take     = in_valid && in_ready;
  assign cfg_tall = cfg_v6 || ((mode_e'(cfg_mode) == MD_HV) && cfg_h6);

  subpel_row_filter #(.LANES(MAX_W), .PIX_W(PIX_W), .ACC_W(ACC_W), .SHIFT(SHIFT)) u_hfilt (
    .row  (in_pk),
    .coef (kh_q),
    .pix  (hrow)
  );

  always_comb begin
    for (int c = 0; c < MAX_W; c++) raw[c] = in_pk[c + LEFT_MARGIN];
    new_ent = (mode_q == MD_HV) ? hrow : raw;
    for (int c = 0; c < MAX_W; c++) begin
      if (tall_q) begin
        for (int t = 0; t < WIN; t++) vsmp[c][t] = win_q[t][c];
        vsmp[c][TAPS-1] = new_ent[c];
      end else begin
        for (int t = 0; t < WIN - 1; t++) vsmp[c][t] = win_q[t+1][c];
        vsmp[c][TAPS-2] = new_ent[c];
        vsmp[c][TAPS-1] = '0;
      end
    end
  end

  for (genvar c = 0; c < MAX_W; c++) begin : g_vlane
    subpel_tap_mac #(.PIX_W(PIX_W), .ACC_W(ACC_W), .SHIFT(SHIFT)) u_vmac (
      .smp  (vsmp[c]),
      .coef (kv_q),
      .pix  (vrow[c])
    );
  end

  always_comb begin
    for (int c = 0; c < MAX_W; c++) begin
      if (c < (4 << wcode_q))
        res[c] = (mode_q == MD_H) ? hrow[c] : vrow[c];
      else
        res[c] = '0;
    end
  end

  // next state
  always_comb begin
    busy_n  = busy_q;
    ov_n    = ov_q;
    prime_n = prime_q;
    left_n  = left_q;
    win_n   = win_q;
    if (ov_q && out_ready) ov_n = 1'b0;
    if (start_ok) begin
      busy_n  = 1'b1;
      left_n  = cfg_rows;
      if (mode_e'(cfg_mode) == MD_H) prime_n = '0;
      else                           prime_n = cfg_tall ? PRIME_TALL : PRIME_SHORT;
    end
    if (take) begin
      for (int t = 0; t < WIN - 1; t++) win_n[t] = win_q[t+1];
      win_n[WIN-1] = new_ent;
      if (prime_q != '0) begin
        prime_n = prime_q - 3'd1;
      end else begin
        ov_n   = 1'b1;
        left_n = left_q - 1'b1;
        if (left_q == ROWS_W'(1)) busy_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      busy_q  <= 1'b0;
      ov_q    <= 1'b0;
      prime_q <= '0;
      left_q  <= '0;
    end else begin
      busy_q  <= busy_n;
      ov_q    <= ov_n;
      prime_q <= prime_n;
      left_q  <= left_n;
    end
  end

  always_ff @(posedge clk) begin
    if (start_ok) begin
      mode_q  <= mode_e'(cfg_mode);
      kh_q    <= pick_kernel(cfg_frac_h, cfg_h6);
      kv_q    <= pick_kernel(cfg_frac_v, cfg_v6);
      tall_q  <= cfg_tall;
      wcode_q <= cfg_width;
    end
    if (take) win_q <= win_n;
    if (take && prime_q == '0) orow_q <= res;
  end

  assign busy      = busy_q || ov_q;
  assign out_valid = ov_q;
  assign out_row   = orow_q;
endmodule

// File: rtl/subpel_filter_chk.sv
module subpel_filter_chk #(
  parameter int MAX_W  = 16,
  parameter int PIX_W  = 8,
  parameter int ROWS_W = 5
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     start,
  input logic [1:0]               cfg_mode,
  input logic [2:0]               cfg_frac_h,
  input logic [2:0]               cfg_frac_v,
  input logic [1:0]               cfg_width,
  input logic [ROWS_W-1:0]        cfg_rows,
  input logic                     busy,
  input logic                     in_ready,
  input logic                     out_valid,
  input logic                     out_ready,
  input logic [MAX_W*PIX_W-1:0]   out_row
);
  logic [ROWS_W:0]   seen_q;
  logic [ROWS_W-1:0] want_q;
  logic [1:0]        wq;
  logic              upper_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
      want_q <= '0;
      wq     <= '0;
    end else if (start && !busy) begin
      seen_q <= '0;
      want_q <= cfg_rows;
      wq     <= cfg_width;
    end else if (out_valid && out_ready) begin
      seen_q <= seen_q + 1'b1;
    end
  end

  always_comb begin
    upper_zero = 1'b1;
    for (int c = 0; c < MAX_W; c++)
      if (c >= (4 << wq) && out_row[c*PIX_W +: PIX_W] != '0) upper_zero = 1'b0;
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_row));
  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !in_ready);
  p_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> seen_q == {1'b0, want_q});
  p_lane_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> upper_zero);
  p_frac_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && cfg_mode != 2'd2 |-> cfg_frac_h != 3'd0);
  p_frac_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && cfg_mode[1] |-> cfg_frac_v != 3'd0);
endmodule

bind subpel_filter subpel_filter_chk #(.MAX_W(MAX_W), .PIX_W(PIX_W), .ROWS_W(ROWS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .cfg_mode   (cfg_mode),
  .cfg_frac_h (cfg_frac_h),
  .cfg_frac_v (cfg_frac_v),
  .cfg_width  (cfg_width),
  .cfg_rows   (cfg_rows),
  .busy       (busy),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_row    (out_row)
);

// File: tb/subpel_filter_tb.sv
module subpel_filter_tb;
  localparam int W  = 16;
  localparam int IW = W + 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] cfg_mode = '0;
  logic [2:0] cfg_frac_h = 3'd1, cfg_frac_v = 3'd1;
  logic cfg_h6 = 1'b0, cfg_v6 = 1'b0;
  logic [1:0] cfg_width = '0;
  logic [4:0] cfg_rows = '0;
  logic busy, in_ready, out_valid;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic [IW*8-1:0] in_row = '0;
  logic [W*8-1:0]  out_row;

  always #5 clk = ~clk;

  subpel_filter u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_mode(cfg_mode),
    .cfg_frac_h(cfg_frac_h), .cfg_frac_v(cfg_frac_v), .cfg_h6(cfg_h6),
    .cfg_v6(cfg_v6), .cfg_width(cfg_width), .cfg_rows(cfg_rows), .busy(busy),
    .in_valid(in_valid), .in_ready(in_ready), .in_row(in_row),
    .out_valid(out_valid), .out_ready(out_ready), .out_row(out_row)
  );

  int n_chk = 0, n_err = 0;
  bit bp = 1'b0, live = 1'b0, pend_pop = 1'b0, ended = 1'b0;
  string tag = "";
  logic [W*8-1:0] exp_q[$];
  int src[40][IW];
  int mid[40][W];

  task automatic check(input bit ok, input string req, input logic [W*8-1:0] act,
                       input logic [W*8-1:0] expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  function automatic int coef(int frac, bit six, int i);
    int t[7][6] = '{'{0,-6,123,12,-1,0}, '{2,-11,108,36,-8,1}, '{0,-9,93,50,-6,0},
                    '{3,-16,77,77,-16,3}, '{0,-6,50,93,-9,0}, '{1,-8,36,108,-11,2},
                    '{0,-1,12,123,-6,0}};
    if (!six && (i == 0 || i == 5)) return 0;
    return t[frac-1][i];
  endfunction

  function automatic int clip(int s);
    int v = (s + 64) >>> 7;
    if (v < 0) return 0;
    if (v > 255) return 255;
    return v;
  endfunction

  // output monitor and consumer
  always @(negedge clk) begin
    if (live) begin
      if (pend_pop && exp_q.size() > 0) void'(exp_q.pop_front());
      if (out_valid) begin
        if (exp_q.size() == 0) check(1'b0, {tag, " R8 extra row"}, out_row, '0);
        else check(out_row === exp_q[0], tag, out_row, exp_q[0]);
      end
      out_ready = bp ? ($urandom % 3 != 0) : 1'b1;
      pend_pop = out_valid && out_ready;
      #1;
      if (out_valid && !out_ready) check(!in_ready, "R9 stall", {127'd0, in_ready}, '0);
    end
  end

  task automatic send_row(input int j);
    logic [IW*8-1:0] v;
    for (int b = 0; b < IW; b++) v[8*b +: 8] = src[j][b][7:0];
    @(negedge clk);
    in_row = v;
    in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
  endtask

  task automatic run_job(input string t, input int mode, input int fh, input int fv,
                         input bit h6, input bit v6, input int wc, input int rows,
                         input int pat, input bit use_bp, input bit poke);
    bit tall = v6 || (mode == 3 && h6);
    int nin = (mode == 1) ? rows : rows + (tall ? 5 : 3);
    int base = tall ? 2 : 1;
    int wid = 4 << wc;
    int tries;
    for (int j = 0; j < nin; j++) begin
      for (int b = 0; b < IW; b++)
        src[j][b] = (pat == 0) ? int'($urandom % 256) : (pat == 1) ? 255 * int'($urandom % 2) : 255;
      for (int c = 0; c < W; c++) begin
        int s = 0;
        for (int i = 0; i < 6; i++) s += coef(fh, h6, i) * src[j][c+i];
        mid[j][c] = clip(s);
      end
    end
    for (int r = 0; r < rows; r++) begin
      logic [W*8-1:0] e = '0;
      for (int c = 0; c < wid && c < W; c++) begin
        if (mode == 1) e[8*c +: 8] = mid[r][c][7:0];
        else begin
          int s = 0;
          for (int o = 0; o < 6; o++) begin
            int j = r + base + o - 2;
            if (j >= 0 && j < nin) s += coef(fv, v6, o) * ((mode == 3) ? mid[j][c] : src[j][c+2]);
          end
          e[8*c +: 8] = 8'(clip(s));
        end
      end
      exp_q.push_back(e);
    end
    tag = t;
    bp = use_bp;
    @(negedge clk);
    cfg_mode = 2'(mode); cfg_frac_h = 3'(fh); cfg_frac_v = 3'(fv);
    cfg_h6 = h6; cfg_v6 = v6; cfg_width = 2'(wc); cfg_rows = 5'(rows);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1;
    check(busy === 1'b1, "R11 start taken when idle", {127'd0, busy}, 1);
    for (int j = 0; j < nin; j++) begin
      if (poke && j == 2) begin
        @(negedge clk);
        in_valid = 1'b0;
        cfg_mode = 2'd1; cfg_frac_h = 3'd4; cfg_rows = 5'd1; cfg_width = 2'd0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
      send_row(j);
    end
    @(negedge clk);
    in_valid = 1'b0;
    tries = 0;
    while (busy && tries < 3000) begin
      @(negedge clk);
      tries++;
    end
    @(negedge clk);
    #2;
    check(!busy && exp_q.size() == 0, {t, " R8 row count"}, 128'(exp_q.size()), '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid && !busy && !in_ready, "R10 in reset",
          {125'd0, out_valid, busy, in_ready}, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(!out_valid && !busy && !in_ready, "R10 after reset",
          {125'd0, out_valid, busy, in_ready}, '0);
    check(!in_ready, "R11 idle in_ready", {127'd0, in_ready}, '0);
    live = 1'b1;
    run_job("R1",        1, 1, 1, 1, 1, 2, 3, 0, 0, 0);
    run_job("R1 R7",     1, 5, 1, 1, 1, 0, 2, 0, 1, 0);
    run_job("R2",        1, 2, 1, 0, 0, 2, 3, 1, 0, 0);
    run_job("R2 R7",     1, 4, 1, 0, 0, 1, 2, 0, 0, 0);
    run_job("R3",        1, 4, 1, 1, 0, 2, 4, 1, 0, 0);
    run_job("R3 R9",     1, 7, 1, 1, 0, 2, 3, 2, 1, 0);
    run_job("R4 R7",     2, 1, 2, 0, 1, 0, 4, 0, 0, 0);
    run_job("R4 R2 R9",  2, 1, 6, 0, 0, 2, 3, 1, 1, 0);
    run_job("R5 R6",     3, 3, 5, 1, 1, 2, 5, 0, 0, 0);
    run_job("R5 R6 R2",  3, 7, 1, 0, 0, 1, 3, 0, 0, 0);
    run_job("R5 R3",     3, 2, 4, 1, 0, 2, 3, 1, 0, 0);
    run_job("R5 R9",     3, 6, 2, 0, 1, 0, 4, 1, 1, 0);
    run_job("R6",        2, 1, 4, 0, 1, 2, 12, 0, 1, 0);
    run_job("R11 poke",  2, 1, 5, 0, 1, 2, 3, 0, 0, 1);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end
endmodule